// File: doc/BRIEF.md
# Privilege-Filtered Event Counter with Sticky Overflow

This block is a single programmable hardware performance counter for a processor core. Each cycle it may receive one event pulse. The pulse adds one to the count unless one of two things blocks it. The first is a per-counter stop input. The second is a set of five mode-inhibit bits, chosen by the current privilege level and by whether the hart runs virtualized. When the count passes its all-ones value it returns to zero. At that point the block sets a sticky overflow flag. It raises a local overflow interrupt request only if the flag was clear before.

The count is 64 bits wide and can be viewed in two ways. In full mode it is one 64-bit quantity. In split mode it is a low and a high 32-bit half, with a carry rule of their own. Software-side decoding lives outside the block. The block accepts half-wise count writes, writes of the control word that holds the flag and the inhibit bits, and an interrupt clear strobe.

Top module: `hpc_counter`

## Requirements
- R1: After reset the count is zero, the overflow flag is 0, the interrupt request is 0 and all five inhibit bits are 0.
- R2: With privilege level 2'b11 (machine), a pulse is not counted while the machine-inhibit bit is set; the virtualization input has no effect in this mode.
- R3: With privilege level 2'b01 (supervisor), the virtual-supervisor inhibit bit blocks counting when virtualization is on, and the supervisor inhibit bit blocks it when virtualization is off.
- R4: With privilege level 2'b00 (user), the virtual-user inhibit bit blocks counting when virtualization is on, and the user inhibit bit blocks it when virtualization is off; level 2'b10 is never filtered.
- R5: A pulse is not counted while `cnt_inhibit` is 1.
- R6: In full mode each counted pulse adds one to the 64-bit count, and a counted pulse at all ones gives zero.
- R7: In split mode a counted pulse adds one to the low half while the low half is not all ones. Otherwise the pulse adds one to the high half and leaves the low half unchanged. When both halves are all ones the count becomes zero.
- R8: On a wrap with the flag clear, the flag and the interrupt request are both set in the same cycle. On a wrap with the flag already set, the flag stays set and no new request is raised.
- R9: The control field is `ctl_wr_data` = {flag[5], machine[4], supervisor[3], user[2], virtual-supervisor[1], virtual-user[0]} (word bits 63..58). In split mode it is loaded only by `ctl_wr_en[1]` (upper word); in full mode only by `ctl_wr_en[0]`; the other enable is ignored. Loaded inhibit bits govern pulses from the next cycle on.
- R10: `cnt_wr_en[0]` loads count bits 31:0 and `cnt_wr_en[1]` loads bits 63:32 from `cnt_wr_data`. While either enable is set, no pulse is counted in that cycle.
- R11: The interrupt request stays 1 until `irq_clr`. A software write of flag 0 re-arms it for the next wrap. If a wrap and a software flag write fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 1 | One event this cycle |
| priv_lvl | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_on | input | 1 | Hart runs virtualized |
| cnt_inhibit | input | 1 | Per-counter stop bit |
| split_mode | input | 1 | 1: two 32-bit halves, 0: one 64-bit count |
| cnt_wr_en | input | 2 | Half-wise count write enables (bit 0 low, bit 1 high) |
| cnt_wr_data | input | 64 | Count write data |
| ctl_wr_en | input | 2 | Control word write enables (bit 0 lower/single word, bit 1 upper word) |
| ctl_wr_data | input | 6 | Flag and inhibit field being written |
| irq_clr | input | 1 | Clears the interrupt request |
| count_o | output | 64 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest state to reach from the ports is a wrap. By events alone, a wrap would take 2^64 pulses, and the split-mode path where the high half carries while the low half stays saturated needs 2^32 pulses. The stimulus loads all-ones and near-all-ones patterns through the half-wise count writes, in both modes. It then pulses the counter under random filtering. A wrap is then met with the flag clear, with the flag set, after an interrupt clear, and in the same cycle as a software flag write.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  // privilege level encoding as seen on priv_lvl
  typedef enum logic [1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPER = 2'b01,
    PRV_RSVD  = 2'b10,
    PRV_MACH  = 2'b11
  } hpc_priv_e;

  // mode inhibit bits, packed in control-field order
  typedef struct packed {
    logic mach;
    logic sup;
    logic usr;
    logic vsup;
    logic vusr;
  } hpc_inh_t;

  localparam int CTL_W  = 6;
  localparam int OF_POS = CTL_W - 1;

  // is a pulse blocked by the mode filter in this privilege/virt state
  function automatic logic mode_blocked(input hpc_priv_e p, input logic v,
                                        input hpc_inh_t b);
    case (p)
      PRV_MACH:  return b.mach;
      PRV_SUPER: return v ? b.vsup : b.sup;
      PRV_USER:  return v ? b.vusr : b.usr;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hpc_evt_filter.sv
module hpc_evt_filter
  import hpc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_pulse,
  input  logic [1:0]          priv_lvl,
  input  logic                virt_on,
  input  logic                cnt_inhibit,
  input  logic                split_mode,
  input  logic [1:0]          ctl_wr_en,
  input  logic [CTL_W-2:0]    inh_wr_bits,
  output logic                ctl_take,
  output logic                evt_ok
);

  hpc_inh_t inh_q;
  logic     mode_blk;

  // split mode: upper word carries the field; full mode: the single word
  assign ctl_take = split_mode ? ctl_wr_en[1] : ctl_wr_en[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        inh_q <= '0;
    else if (ctl_take) inh_q <= hpc_inh_t'(inh_wr_bits);
  end

  assign mode_blk = mode_blocked(hpc_priv_e'(priv_lvl), virt_on, inh_q);
  assign evt_ok   = evt_pulse & ~cnt_inhibit & ~mode_blk;

  AST_MACH_VIRT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == 2'b11) |-> (mode_blk == inh_q.mach)) else $error("mach filter"); // R2

endmodule

// File: rtl/hpc_count_core.sv
module hpc_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_ok,
  input  logic             split_mode,
  input  logic [1:0]       cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);

  localparam int HALF_W   = CNT_W / 2;
  localparam int NUM_HALF = 2;
  localparam logic [HALF_W-1:0] ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  ONE_F = {{(CNT_W-1){1'b0}}, 1'b1};

  // next count for one counted pulse
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c,
                                            input logic split);
    logic [HALF_W-1:0] lo, hi;
    lo = c[HALF_W-1:0];
    hi = c[CNT_W-1:HALF_W];
    if (!split)       return c + ONE_F;
    if (lo != '1)     return {hi, lo + ONE_H};
    if (hi != '1)     return {hi + ONE_H, lo};
    return '0;
  endfunction

  logic             wr_any;
  logic             inc;
  logic [CNT_W-1:0] bumped;
  logic [CNT_W-1:0] cnt_d;

  assign wr_any   = |cnt_wr_en;
  assign inc      = evt_ok & ~wr_any;
  assign bumped   = bump(cnt_q, split_mode);
  assign wrap_evt = inc & (cnt_q == '1);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign cnt_d[h*HALF_W +: HALF_W] =
      cnt_wr_en[h] ? cnt_wr_data[h*HALF_W +: HALF_W] :
      inc          ? bumped[h*HALF_W +: HALF_W]      :
                     cnt_q[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0)) else $error("wrap not zero"); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en[0] |=> (cnt_q[HALF_W-1:0] == $past(cnt_wr_data[HALF_W-1:0])))
    else $error("write lost"); // R10
  AST_SPLIT_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && split_mode && cnt_q[HALF_W-1:0] == '1 && cnt_q[CNT_W-1:HALF_W] != '1)
    |=> (cnt_q[HALF_W-1:0] == '1)) else $error("low half moved"); // R7

endmodule

// File: rtl/hpc_ovf_ctl.sv
module hpc_ovf_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic sw_of_we,
  input  logic sw_of_val,
  input  logic irq_clr,
  output logic flag_q,
  output logic irq_q
);

  logic raise;

  assign raise = wrap_evt & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // hardware set beats a same-cycle software write
      if (wrap_evt)      flag_q <= 1'b1;
      else if (sw_of_we) flag_q <= sw_of_val;
      if (raise)         irq_q  <= 1'b1;
      else if (irq_clr)  irq_q  <= 1'b0;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(sw_of_we && !sw_of_val)) |=> flag_q) else $error("flag dropped"); // R8
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $rose(flag_q)) else $error("irq without arm"); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q) else $error("irq dropped"); // R11

endmodule

// File: rtl/hpc_counter.sv
module hpc_counter
  import hpc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pulse,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_on,
  input  logic             cnt_inhibit,
  input  logic             split_mode,
  input  logic [1:0]       cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic [1:0]       ctl_wr_en,
  input  logic [5:0]       ctl_wr_data,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             ovf_irq_o
);

  logic ctl_take;
  logic evt_ok;
  logic wrap_evt;

  hpc_evt_filter u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .priv_lvl    (priv_lvl),
    .virt_on     (virt_on),
    .cnt_inhibit (cnt_inhibit),
    .split_mode  (split_mode),
    .ctl_wr_en   (ctl_wr_en),
    .inh_wr_bits (ctl_wr_data[CTL_W-2:0]),
    .ctl_take    (ctl_take),
    .evt_ok      (evt_ok)
  );

  hpc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_ok      (evt_ok),
    .split_mode  (split_mode),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .cnt_q       (count_o),
    .wrap_evt    (wrap_evt)
  );

  hpc_ovf_ctl u_ovf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_evt  (wrap_evt),
    .sw_of_we  (ctl_take),
    .sw_of_val (ctl_wr_data[OF_POS]),
    .irq_clr   (irq_clr),
    .flag_q    (ovf_flag_o),
    .irq_q     (ovf_irq_o)
  );

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && cnt_inhibit && cnt_wr_en == 2'b00) |=> $stable(count_o))
    else $error("stopped counter moved"); // R5

endmodule

// File: tb/sim_hpc_counter.sv
`timescale 1ns/1ps
module sim_hpc_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_pulse = 1'b0;
  logic [1:0]  priv_lvl = 2'b00;
  logic        virt_on = 1'b0;
  logic        cnt_inhibit = 1'b0;
  logic        split_mode = 1'b0;
  logic [1:0]  cnt_wr_en = 2'b00;
  logic [63:0] cnt_wr_data = '0;
  logic [1:0]  ctl_wr_en = 2'b00;
  logic [5:0]  ctl_wr_data = '0;
  logic        irq_clr = 1'b0;
  logic [63:0] count_o;
  logic        ovf_flag_o;
  logic        ovf_irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  // reference state
  logic [63:0] m_cnt = '0;
  logic        m_of = 1'b0;
  logic        m_irq = 1'b0;
  logic [4:0]  m_inh = '0; // {M,S,U,VS,VU}

  always #2 clk = ~clk; // 250 MHz

  hpc_counter u0 (.*);

  function automatic logic ref_blocked(input logic [1:0] p, input logic v,
                                       input logic [4:0] b);
    if (p == 2'b11) return b[4];
    if (p == 2'b01) return v ? b[1] : b[3];
    if (p == 2'b00) return v ? b[0] : b[2];
    return 1'b0;
  endfunction

  function automatic logic [63:0] ref_step(input logic [63:0] c, input logic sp);
    if (c == ALL1) return 64'd0;
    if (!sp) return c + 64'd1;
    if (c[31:0] != 32'hFFFF_FFFF) return {c[63:32], c[31:0] + 32'd1};
    return {c[63:32] + 32'd1, c[31:0]};
  endfunction

  task automatic cyc(input logic ev, input logic [1:0] pr, input logic vt,
                     input logic ci, input logic sp, input logic [1:0] cwe,
                     input logic [63:0] cwd, input logic [1:0] kwe,
                     input logic [5:0] kwd, input logic clr);
    logic counted, wrap, take;
    logic [63:0] n_cnt;
    evt_pulse = ev; priv_lvl = pr; virt_on = vt; cnt_inhibit = ci;
    split_mode = sp; cnt_wr_en = cwe; cnt_wr_data = cwd;
    ctl_wr_en = kwe; ctl_wr_data = kwd; irq_clr = clr;
    take    = sp ? kwe[1] : kwe[0];
    counted = ev && !ci && !ref_blocked(pr, vt, m_inh) && cwe == 2'b00;
    wrap    = counted && m_cnt == ALL1;
    n_cnt   = counted ? ref_step(m_cnt, sp) : m_cnt;
    if (cwe[0]) n_cnt[31:0]  = cwd[31:0];
    if (cwe[1]) n_cnt[63:32] = cwd[63:32];
    @(posedge clk); #1;
    m_irq = (wrap && !m_of) ? 1'b1 : (clr ? 1'b0 : m_irq);
    m_of  = wrap ? 1'b1 : (take ? kwd[5] : m_of);
    if (take) m_inh = kwd[4:0];
    m_cnt = n_cnt;
  endtask

  task automatic ev1(input logic [1:0] pr, input logic vt, input logic sp);
    cyc(1'b1, pr, vt, 1'b0, sp, 2'b00, '0, 2'b00, '0, 1'b0);
  endtask

  task automatic wr_cnt(input logic [63:0] d, input logic sp);
    cyc(1'b0, 2'b00, 1'b0, 1'b0, sp, 2'b11, d, 2'b00, '0, 1'b0);
  endtask

  task automatic wr_ctl(input logic [1:0] kwe, input logic [5:0] d, input logic sp);
    cyc(1'b0, 2'b00, 1'b0, 1'b0, sp, 2'b00, '0, kwe, d, 1'b0);
  endtask

  task automatic check(input string tag);
    tests++;
    if (count_o !== m_cnt || ovf_flag_o !== m_of || ovf_irq_o !== m_irq) begin
      fails++;
      $display("FAIL %s: count=%h flag=%b irq=%b expected count=%h flag=%b irq=%b",
               tag, count_o, ovf_flag_o, ovf_irq_o, m_cnt, m_of, m_irq);
    end
  endtask

  task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check_val("R1 count", count_o, 64'd0);
    check_val("R1 flag/irq", {62'd0, ovf_flag_o, ovf_irq_o}, 64'd0);
    // R6 plain counting in full mode
    repeat (3) ev1(2'b00, 1'b0, 1'b0);
    check_val("R6 three pulses", count_o, 64'd3);
    // R4 inhibit bits are zero after reset: every mode counts
    ev1(2'b11, 1'b1, 1'b0); ev1(2'b01, 1'b1, 1'b0); ev1(2'b00, 1'b1, 1'b0);
    check_val("R1 inhibits clear", count_o, 64'd6);
    // R2 machine inhibit, virt ignored
    wr_ctl(2'b01, 6'b010000, 1'b0);
    ev1(2'b11, 1'b0, 1'b0); ev1(2'b11, 1'b1, 1'b0); check("R2 machine blocked");
    ev1(2'b01, 1'b0, 1'b0); check("R2 supervisor still counts");
    // R9 wrong enable in full mode ignored
    wr_ctl(2'b10, 6'b001111, 1'b0);
    ev1(2'b01, 1'b0, 1'b0); ev1(2'b00, 1'b1, 1'b0); check("R9 upper enable ignored in full mode");
    // R3 supervisor pair
    wr_ctl(2'b01, 6'b000010, 1'b0);
    ev1(2'b01, 1'b1, 1'b0); check("R3 virtual supervisor blocked");
    ev1(2'b01, 1'b0, 1'b0); check("R3 supervisor counts");
    wr_ctl(2'b01, 6'b001000, 1'b0);
    ev1(2'b01, 1'b0, 1'b0); ev1(2'b01, 1'b1, 1'b0); check("R3 supervisor inhibit");
    // R4 user pair and reserved level
    wr_ctl(2'b01, 6'b000001, 1'b0);
    ev1(2'b00, 1'b1, 1'b0); ev1(2'b00, 1'b0, 1'b0); check("R4 virtual user");
    wr_ctl(2'b01, 6'b000100, 1'b0);
    ev1(2'b00, 1'b0, 1'b0); ev1(2'b00, 1'b1, 1'b0); ev1(2'b10, 1'b0, 1'b0); check("R4 user inhibit");
    wr_ctl(2'b01, 6'b000000, 1'b0);
    // R5 stop input
    cyc(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, '0, 2'b00, '0, 1'b0);
    check("R5 stopped");
    // R6 / R8 wrap with flag clear
    wr_cnt(ALL1, 1'b0);
    ev1(2'b00, 1'b0, 1'b0);
    check_val("R6 wrap to zero", count_o, 64'd0);
    check_val("R8 flag and irq set", {62'd0, ovf_flag_o, ovf_irq_o}, 64'd3);
    // R8 wrap with flag set: no new request after clear
    cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, '0, 2'b00, '0, 1'b1);
    check("R11 irq cleared");
    wr_cnt(ALL1, 1'b0); ev1(2'b00, 1'b0, 1'b0);
    check_val("R8 no second request", {62'd0, ovf_flag_o, ovf_irq_o}, 64'd2);
    // R11 re-arm by clearing the flag
    wr_ctl(2'b01, 6'b000000, 1'b0);
    wr_cnt(ALL1, 1'b0); ev1(2'b00, 1'b0, 1'b0);
    check_val("R11 re-armed request", {62'd0, ovf_flag_o, ovf_irq_o}, 64'd3);
    // R11 wrap beats same-cycle software clear
    wr_cnt(ALL1, 1'b0);
    cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, '0, 2'b01, 6'b000000, 1'b0);
    check_val("R11 flag wins", {63'd0, ovf_flag_o}, 64'd1);
    // R7 split carry rule
    wr_cnt({32'd5, 32'hFFFF_FFFE}, 1'b1);
    ev1(2'b00, 1'b0, 1'b1);
    check_val("R7 low reaches ones", count_o, {32'd5, 32'hFFFF_FFFF});
    ev1(2'b00, 1'b0, 1'b1);
    check_val("R7 high carries, low held", count_o, {32'd6, 32'hFFFF_FFFF});
    wr_cnt(ALL1, 1'b1); ev1(2'b00, 1'b0, 1'b1);
    check_val("R7 split wrap", count_o, 64'd0);
    // R9 split mode uses upper word only
    wr_ctl(2'b01, 6'b010000, 1'b1);
    ev1(2'b11, 1'b0, 1'b1); check("R9 lower enable ignored in split mode");
    wr_ctl(2'b10, 6'b010000, 1'b1);
    ev1(2'b11, 1'b0, 1'b1); check("R9 upper enable in split mode");
    wr_ctl(2'b10, 6'b000000, 1'b1);
    // R10 write beats increment
    wr_cnt({32'hAAAA_0000, 32'h10}, 1'b0);
    cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01, 64'h0000_0000_0000_1234, 2'b00, '0, 1'b0);
    check_val("R10 low write, no increment", count_o, {32'hAAAA_0000, 32'h1234});
    cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b10, 64'h0000_0077_0000_0000, 2'b00, '0, 1'b0);
    check_val("R10 high write, no increment", count_o, {32'h77, 32'h1234});
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  cwe, kwe;
      logic [63:0] d;
      logic [5:0]  k;
      cwe = ($urandom % 12 == 0) ? 2'($urandom) : 2'b00;
      kwe = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
      k   = 6'($urandom) & 6'b100000 | (($urandom % 2 == 0) ? 6'($urandom) & 6'b011111 : 6'd0);
      case ($urandom % 4)
        0: d = ALL1;
        1: d = ALL1 - 64'($urandom % 3);
        2: d = {32'($urandom), 32'hFFFF_FFFF - 32'($urandom % 2)};
        default: d = {32'($urandom), 32'($urandom)};
      endcase
      cyc($urandom % 10 < 7, 2'($urandom), 1'($urandom), $urandom % 6 == 0,
          $urandom % 2 == 0, cwe, d, kwe, k, $urandom % 10 == 0);
      check((i % 2 == 0) ? "R6 R7 R10 random" : "R2 R3 R4 R5 R8 R9 R11 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule